// File: doc/BRIEF.md
# Quarter-Period Quadrature Sampling Demodulator

This block turns a stream of signed ADC samples of an intermediate-frequency carrier into in-phase and quadrature values. The ADC clock runs at four times the carrier, so each sample sits a quarter period after the one before it. Every sample is paired with the sample before it, and that pair is treated as the two components of a phasor.

Each new sample moves the carrier a further 90 degrees. To cancel this, the pair is rotated back by a multiple of 90 degrees that depends on the position of the sample in the four-sample cycle. The rotation uses only swaps and sign changes, so no multipliers are needed. With a steady input, I and Q stay constant. After the second sample, the block gives one result for every input sample, and the output is registered once.

The sampled quantity is the vertical (sine) part of a phasor that turns counterclockwise. A carrier with components (I0, Q0) therefore gives the repeating samples Q0, I0, -Q0, -I0.

Top module: `iq_quad_demod`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `out_valid` is 0 and `out_i` and `out_q` are 0.
- R2: The first valid sample after reset produces no output. For every later valid sample, `out_valid` is 1 for exactly one cycle, in the cycle after the edge that accepted the sample.
- R3: The position k counts accepted samples modulo 4, starting at 0 after reset. Take c as the current sample and p as the previous accepted sample. The outputs are: for k=1, I=c and Q=p; for k=2, I=p and Q=-c; for k=3, I=-c and Q=-p; for k=0, I=-p and Q=c.
- R4: An input that repeats Q0, I0, -Q0, -I0 gives I=I0 and Q=Q0 on every output once one full sample pair of that input has been accepted.
- R5: When the most negative value -2^(DATA_W-1) is negated, the result is the most positive value 2^(DATA_W-1)-1. The result does not wrap.
- R6: A cycle with `in_valid` low gives `out_valid` low in the next cycle and leaves `out_i` and `out_q` unchanged. It also leaves the position count and the stored sample unchanged.
- R7: A reset in the middle of a stream restarts the position count at 0 and discards the stored sample. The first sample after the reset again produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | DATA_W | Signed ADC sample |
| out_valid | output | 1 | Result strobe |
| out_i | output | DATA_W | Signed in-phase result |
| out_q | output | DATA_W | Signed quadrature result |

## Verification
A position counter that is out of step shows up on the next output as a swapped or wrongly signed pair. With a steady carrier, that output turns into one of the other three 90-degree images of the true vector. A stale stored sample corrupts one component of the next result only. A wrong pairing flag moves the first `out_valid` one sample earlier or later. Every one of these faults can be seen at the ports within one or two samples, so a short stream from reset with known values catches them.

// File: rtl/iq_quad_demod.sv
module iq_quad_demod #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_sample,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_i,
  output logic [DATA_W-1:0] out_q
);
  localparam logic [DATA_W-1:0] S_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] S_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  function automatic logic [DATA_W-1:0] neg_sat(input logic [DATA_W-1:0] v);
    return (v == S_MIN) ? S_MAX : (~v + 1'b1);
  endfunction

  logic [1:0]        phase;
  logic              have_prev;
  logic [DATA_W-1:0] prev;
  logic [DATA_W-1:0] rot_i, rot_q;

  always_comb begin
    case (phase)
      2'd1:    begin rot_i = in_sample;          rot_q = prev;               end
      2'd2:    begin rot_i = prev;               rot_q = neg_sat(in_sample); end
      2'd3:    begin rot_i = neg_sat(in_sample); rot_q = neg_sat(prev);      end
      default: begin rot_i = neg_sat(prev);      rot_q = in_sample;          end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= '0;
      have_prev <= 1'b0;
      prev      <= '0;
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= in_valid & have_prev;
      if (in_valid) begin
        phase     <= phase + 2'd1;
        have_prev <= 1'b1;
        prev      <= in_sample;
        if (have_prev) begin
          out_i <= rot_i;
          out_q <= rot_q;
        end
      end
    end
  end
endmodule

// File: rtl/iq_quad_demod_chk.sv
module iq_quad_demod_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_sample,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_i,
  input logic [DATA_W-1:0] out_q,
  input logic [1:0]        phase,
  input logic              have_prev
);
  localparam logic [DATA_W-1:0] S_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] S_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_i == '0 && out_q == '0));

  p_first_silent_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !have_prev) |=> !out_valid);

  p_valid_source_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && have_prev) |=> out_valid);

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_i) && $stable(out_q)));

  p_sat_q_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && have_prev && phase == 2'd2 && in_sample == S_MIN) |=> (out_q == S_MAX));

  p_sat_i_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && have_prev && phase == 2'd3 && in_sample == S_MIN) |=> (out_i == S_MAX));

  p_restart_r7: assert property (@(posedge clk)
    rst |=> (phase == 2'd0 && !have_prev));
endmodule

bind iq_quad_demod iq_quad_demod_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
  .out_valid(out_valid), .out_i(out_i), .out_q(out_q),
  .phase(phase), .have_prev(have_prev)
);

// File: tb/tb_iq_quad_demod.sv
module tb_iq_quad_demod;
  localparam int W = 16;
  localparam int NV = 16;
  localparam logic [W-1:0] S_MAX = 16'h7FFF;
  localparam logic [W-1:0] S_MIN = 16'h8000;

  logic clk = 0, rst = 1, in_valid = 0;
  logic [W-1:0] in_sample = '0;
  logic out_valid;
  logic [W-1:0] out_i, out_q;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  iq_quad_demod #(.DATA_W(W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  // {sample, has_output, expected I, expected Q}
  localparam logic [3*W:0] VEC [NV] = '{
    {16'sd10,   1'b0, 16'sd0,    16'sd0},
    {16'sd20,   1'b1, 16'sd20,   16'sd10},
    {16'sd30,   1'b1, 16'sd20,  -16'sd30},
    {16'sd40,   1'b1, -16'sd40, -16'sd30},
    {16'sd50,   1'b1, -16'sd40,  16'sd50},
    {16'sd60,   1'b1, 16'sd60,   16'sd50},
    {16'sd70,   1'b1, 16'sd60,  -16'sd70},
    {16'sd80,   1'b1, -16'sd80, -16'sd70},
    {-16'sd700, 1'b1, -16'sd80, -16'sd700},
    {16'sd300,  1'b1, 16'sd300, -16'sd700},
    {16'sd700,  1'b1, 16'sd300, -16'sd700},
    {-16'sd300, 1'b1, 16'sd300, -16'sd700},
    {-16'sd700, 1'b1, 16'sd300, -16'sd700},
    {16'sd300,  1'b1, 16'sd300, -16'sd700},
    {16'sd700,  1'b1, 16'sd300, -16'sd700},
    {-16'sd300, 1'b1, 16'sd300, -16'sd700}
  };

  task automatic chk(input string req, input logic v, input logic [W-1:0] ei,
                     input logic [W-1:0] eq, input logic ev);
    checks++;
    if (out_valid !== ev || (ev && (out_i !== ei || out_q !== eq))) begin
      errors++;
      $display("FAIL %s: valid=%0b i=%0d q=%0d expected valid=%0b i=%0d q=%0d",
               req, out_valid, $signed(out_i), $signed(out_q), ev, $signed(ei), $signed(eq));
    end
  endtask

  task automatic push(input logic [W-1:0] s);
    @(negedge clk);
    in_valid = 1; in_sample = s;
    @(posedge clk); #2;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1; in_valid = 0;
    @(posedge clk); #2;
    @(negedge clk);
    rst = 0;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #2;
    checks++;
    if (out_valid !== 0 || out_i !== 0 || out_q !== 0) begin
      errors++;
      $display("FAIL R1: valid=%0b i=%0d q=%0d expected 0 0 0", out_valid, out_i, out_q);
    end
    @(negedge clk); rst = 0;

    for (int n = 0; n < NV; n++) begin
      push(VEC[n][3*W:2*W+1]);
      chk(n < 8 ? "R3" : (n == 0 ? "R2" : "R4"), 1'b1,
          VEC[n][2*W-1:W], VEC[n][W-1:0], VEC[n][2*W]);
    end

    // R6: idle cycle holds outputs and state
    @(negedge clk); in_valid = 0;
    @(posedge clk); #2;
    chk("R6", 1'b1, 16'sd300, -16'sd700, 1'b0);
    checks++;
    if (out_i !== 16'sd300 || out_q !== -16'sd700) begin
      errors++;
      $display("FAIL R6: i=%0d q=%0d expected 300 -700", $signed(out_i), $signed(out_q));
    end
    push(-16'sd700);
    chk("R6", 1'b1, 16'sd300, -16'sd700, 1'b1);

    // R5: saturation at k=2 (Q) and k=3 (I)
    do_reset();
    push(16'sd5);
    chk("R2", 1'b1, 0, 0, 1'b0);
    push(16'sd6);
    chk("R3", 1'b1, 16'sd6, 16'sd5, 1'b1);
    push(S_MIN);
    chk("R5", 1'b1, 16'sd6, S_MAX, 1'b1);
    push(S_MIN);
    chk("R5", 1'b1, S_MAX, S_MAX, 1'b1);

    // R7: mid-stream reset restarts position
    push(16'sd9);
    do_reset();
    push(16'sd11);
    chk("R7", 1'b1, 0, 0, 1'b0);
    push(16'sd12);
    chk("R7", 1'b1, 16'sd12, 16'sd11, 1'b1);
    @(negedge clk); in_valid = 0;
    @(posedge clk); #2;
    chk("R2", 1'b1, 0, 0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule